// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for a pin count that is a parameter (64 or 96, always a multiple of 32). Software reaches it through a word-addressed register bus with separate read and write strobes. The pins are split into 32-pin banks, and each register group holds one 32-bit word per bank. The groups are the pin level, the pin direction, write-one set and clear ports for the output value, rising and falling edge enables, and a sticky edge-status word. A final group holds a packed 2-bit alternate-function code for each pin.

Pad inputs pass through a two-flop synchronizer. The synchronized value is what the level group returns and what the edge detector sees. A pin whose edge kind is enabled latches its status bit. A single interrupt line stays high while any status bit is pending. Status bits are cleared by writing ones, and an edge that arrives in the same cycle as the clearing write survives. The block drives per-pin output enables and output values, and it exports the stored function codes to the pad mux outside it.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: With NW = NUM_PINS/32, the word address of a register is group × NW + pin/32. The group indices are level 0, direction 1, set 2, clear 3, rising-enable 4, falling-enable 5, edge-status 6, function 7. Pin p uses bit p mod 32. Read data appears on bus_rdata in the cycle after the bus_rd strobe and holds until the next read.
- R2: The level group returns each pin's input after two synchronizer flops. Writes to it change nothing.
- R3: A direction bit of 1 drives pin_oe high for that pin, and 0 releases it. The direction group reads back as written.
- R4: Writing a 1 to a set-port bit drives that pin_out bit high. Zero bits leave pin_out unchanged, and reads of the set port return 0.
- R5: Writing a 1 to a clear-port bit drives that pin_out bit low. Zero bits leave pin_out unchanged, and reads of the clear port return 0.
- R6: With its rising-enable bit set, a low-to-high change of a pin's synchronized input sets its edge-status bit.
- R7: With its falling-enable bit set, a high-to-low change sets the same edge-status bit.
- R8: An edge whose kind is not enabled leaves the edge-status bit unchanged.
- R9: Writing a 1 clears an edge-status bit, and 0 bits have no effect. If an enabled edge is detected in the cycle the clearing write takes effect, the bit stays set.
- R10: irq is high exactly while at least one edge-status bit is set.
- R11: The function group spans 2×NW words starting at word 7×NW. Pin p's 2-bit code sits at bits 2×(p mod 16)+1:2×(p mod 16) of word 7×NW + p/16, and it drives af_sel[2p+1:2p]. The group reads back as written.
- R12: After reset, direction, output, both enable groups, edge status and function codes are all 0, and irq is low.
- R13: Addresses at or above 9×NW read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| pin_in | input | NUM_PINS | Pad input levels |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| pin_out | output | NUM_PINS | Per-pin output value |
| af_sel | output | 2*NUM_PINS | Per-pin alternate-function codes |
| irq | output | 1 | Combined edge interrupt, level |

## Verification
The sharpest corner is a clearing write that lands in the same cycle as a fresh enabled edge on the same pin. A design that gives the clear priority loses that interrupt for good, and the bench times the pin change so that the detection and the write meet on one clock edge. The bench also drives edges of a disabled kind and checks that the status bit stays as it was. A design that ignored the enables, or detected both edges, would raise irq there. Set and clear writes carry zero bits alongside the ones, so a port that wrote the whole word would wipe neighbouring outputs. Reads past the last group, and writes to the level group and to unused addresses, must leave the state alone; a decoder that aliased addresses would show changed registers on readback.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned BANK_W = 32;
  localparam int unsigned N_GRP  = 8;

  typedef enum logic [2:0] {
    GRP_LEVEL = 3'd0,
    GRP_DIR   = 3'd1,
    GRP_SET   = 3'd2,
    GRP_CLR   = 3'd3,
    GRP_RISE  = 3'd4,
    GRP_FALL  = 3'd5,
    GRP_STAT  = 3'd6,
    GRP_FUNC  = 3'd7
  } gpio_grp_e;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NW     = 3,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned WI_W   = 2,
  parameter int unsigned FI_W   = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_GRP-1:0]  grp_sel,
  output logic [WI_W-1:0]   word_idx,
  output logic [FI_W-1:0]   func_idx
);
  localparam int unsigned FUNC_LO = 7 * NW;
  localparam int unsigned FUNC_HI = 9 * NW;

  always_comb begin
    grp_sel  = '0;
    word_idx = '0;
    func_idx = '0;
    for (int g = 0; g < 7; g++) begin
      if (int'(addr) >= g * int'(NW) && int'(addr) < (g + 1) * int'(NW)) begin
        grp_sel[g] = 1'b1;
        word_idx   = WI_W'(int'(addr) - g * int'(NW));
      end
    end
    if (int'(addr) >= int'(FUNC_LO) && int'(addr) < int'(FUNC_HI)) begin
      grp_sel[GRP_FUNC] = 1'b1;
      func_idx          = FI_W'(int'(addr) - int'(FUNC_LO));
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;
endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit #(
  parameter int unsigned WIDTH = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] smp,
  input  logic [WIDTH-1:0] rise_en,
  input  logic [WIDTH-1:0] fall_en,
  input  logic [WIDTH-1:0] clr_mask,
  output logic [WIDTH-1:0] sts,
  output logic             irq
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] sts_q;
  logic [WIDTH-1:0] hit;
  logic [WIDTH-1:0] sts_n;

  always_comb begin
    hit   = (smp & ~prev_q & rise_en) | (~smp & prev_q & fall_en);
    // a new edge wins over the clearing write in the same cycle
    sts_n = (sts_q & ~clr_mask) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      sts_q  <= '0;
    end else begin
      prev_q <= smp;
      sts_q  <= sts_n;
    end
  end

  assign sts = sts_q;
  assign irq = |sts_q;
endmodule

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 96,
  parameter int unsigned WI_W     = 2,
  parameter int unsigned FI_W     = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [N_GRP-1:0]      grp_sel,
  input  logic [WI_W-1:0]       word_idx,
  input  logic [FI_W-1:0]       func_idx,
  input  logic [BANK_W-1:0]     wdata,
  output logic [NUM_PINS-1:0]   dir_q,
  output logic [NUM_PINS-1:0]   out_q,
  output logic [NUM_PINS-1:0]   rise_q,
  output logic [NUM_PINS-1:0]   fall_q,
  output logic [2*NUM_PINS-1:0] func_q,
  output logic [NUM_PINS-1:0]   stat_clr
);
  localparam int unsigned NW = NUM_PINS / BANK_W;
  localparam int unsigned NF = 2 * NW;

  logic [NUM_PINS-1:0]   dir_n, out_n, rise_n, fall_n;
  logic [2*NUM_PINS-1:0] func_n;

  always_comb begin
    dir_n    = dir_q;
    out_n    = out_q;
    rise_n   = rise_q;
    fall_n   = fall_q;
    func_n   = func_q;
    stat_clr = '0;
    for (int w = 0; w < int'(NW); w++) begin
      if (wr_en && word_idx == WI_W'(w)) begin
        if (grp_sel[GRP_DIR])  dir_n[w*BANK_W +: BANK_W]  = wdata;
        if (grp_sel[GRP_SET])  out_n[w*BANK_W +: BANK_W]  = out_q[w*BANK_W +: BANK_W] | wdata;
        if (grp_sel[GRP_CLR])  out_n[w*BANK_W +: BANK_W]  = out_q[w*BANK_W +: BANK_W] & ~wdata;
        if (grp_sel[GRP_RISE]) rise_n[w*BANK_W +: BANK_W] = wdata;
        if (grp_sel[GRP_FALL]) fall_n[w*BANK_W +: BANK_W] = wdata;
        if (grp_sel[GRP_STAT]) stat_clr[w*BANK_W +: BANK_W] = wdata;
      end
    end
    for (int f = 0; f < int'(NF); f++) begin
      if (wr_en && grp_sel[GRP_FUNC] && func_idx == FI_W'(f))
        func_n[f*BANK_W +: BANK_W] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      func_q <= '0;
    end else if (wr_en) begin
      dir_q  <= dir_n;
      out_q  <= out_n;
      rise_q <= rise_n;
      fall_q <= fall_n;
      func_q <= func_n;
    end
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 96,
  parameter int unsigned ADDR_W   = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic [NUM_PINS-1:0]   pin_oe,
  output logic [NUM_PINS-1:0]   pin_out,
  output logic [2*NUM_PINS-1:0] af_sel,
  output logic                  irq
);
  localparam int unsigned NW   = NUM_PINS / BANK_W;
  localparam int unsigned NF   = 2 * NW;
  localparam int unsigned WI_W = (NW > 1) ? $clog2(NW) : 1;
  localparam int unsigned FI_W = $clog2(NF);

  logic [1:0]            rst_pipe;
  logic                  rst_sync_n;
  logic [N_GRP-1:0]      grp_sel;
  logic [WI_W-1:0]       word_idx;
  logic [FI_W-1:0]       func_idx;
  logic [NUM_PINS-1:0]   lvl, dir_q, out_q, rise_q, fall_q, stat_clr, sts;
  logic [2*NUM_PINS-1:0] func_q;
  logic [31:0]           rd_word;
  logic [31:0]           rdata_q;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  gpio_addr_dec #(.NW(NW), .ADDR_W(ADDR_W), .WI_W(WI_W), .FI_W(FI_W)) u_dec (
    .addr(bus_addr), .grp_sel(grp_sel), .word_idx(word_idx), .func_idx(func_idx)
  );

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_async(pin_in), .q_sync(lvl)
  );

  gpio_ctl_regs #(.NUM_PINS(NUM_PINS), .WI_W(WI_W), .FI_W(FI_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(bus_wr), .grp_sel(grp_sel),
    .word_idx(word_idx), .func_idx(func_idx), .wdata(bus_wdata),
    .dir_q(dir_q), .out_q(out_q), .rise_q(rise_q), .fall_q(fall_q),
    .func_q(func_q), .stat_clr(stat_clr)
  );

  gpio_edge_unit #(.WIDTH(NUM_PINS)) u_edge (
    .clk(clk), .rst_n(rst_sync_n), .smp(lvl), .rise_en(rise_q),
    .fall_en(fall_q), .clr_mask(stat_clr), .sts(sts), .irq(irq)
  );

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < int'(NW); w++) begin
      if (word_idx == WI_W'(w)) begin
        if (grp_sel[GRP_LEVEL]) rd_word = lvl[w*BANK_W +: BANK_W];
        if (grp_sel[GRP_DIR])   rd_word = dir_q[w*BANK_W +: BANK_W];
        if (grp_sel[GRP_RISE])  rd_word = rise_q[w*BANK_W +: BANK_W];
        if (grp_sel[GRP_FALL])  rd_word = fall_q[w*BANK_W +: BANK_W];
        if (grp_sel[GRP_STAT])  rd_word = sts[w*BANK_W +: BANK_W];
      end
    end
    for (int f = 0; f < int'(NF); f++) begin
      if (grp_sel[GRP_FUNC] && func_idx == FI_W'(f))
        rd_word = func_q[f*BANK_W +: BANK_W];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata_q <= '0;
    else if (bus_rd)  rdata_q <= rd_word;
  end

  assign bus_rdata = rdata_q;
  assign pin_oe    = dir_q;
  assign pin_out   = out_q;
  assign af_sel    = func_q;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int unsigned NUM_PINS = 96,
  parameter int unsigned ADDR_W   = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] pin_out,
  input logic                irq
);
  localparam int unsigned NW = NUM_PINS / 32;
  localparam logic [ADDR_W-1:0] A_DIR0  = ADDR_W'(NW);
  localparam logic [ADDR_W-1:0] A_SET0  = ADDR_W'(2 * NW);
  localparam logic [ADDR_W-1:0] A_CLR0  = ADDR_W'(3 * NW);
  localparam logic [ADDR_W-1:0] A_RISE0 = ADDR_W'(4 * NW);
  localparam logic [ADDR_W-1:0] A_STAT0 = ADDR_W'(6 * NW);
  localparam logic [ADDR_W-1:0] A_FUNC0 = ADDR_W'(7 * NW);
  localparam logic [ADDR_W-1:0] A_END   = ADDR_W'(9 * NW);

  logic dir_wr, stat_wr, port_rd;
  assign dir_wr  = bus_wr && bus_addr >= A_DIR0 && bus_addr < A_SET0;
  assign stat_wr = bus_wr && bus_addr >= A_STAT0 && bus_addr < A_FUNC0;
  assign port_rd = bus_rd && bus_addr >= A_SET0 && bus_addr < A_RISE0;

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_wr |=> $stable(pin_oe)); // R3

  AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SET0) |=> ((pin_out[31:0] & $past(bus_wdata)) == $past(bus_wdata))); // R4

  AST_CLR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CLR0) |=> ((pin_out[31:0] & $past(bus_wdata)) == 32'h0)); // R5

  AST_PORT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    port_rd |=> (bus_rdata == 32'h0)); // R4

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !stat_wr) |=> irq); // R10

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr >= A_END) |=> (bus_rdata == 32'h0)); // R13
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pin_oe(pin_oe), .pin_out(pin_out), .irq(irq)
);

// File: tb/gpio_bank_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb;
  localparam int unsigned NP = 96;
  localparam int unsigned AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_oe, pin_out;
  logic [2*NP-1:0] af_sel;
  logic          irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic rd_q = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  gpio_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
    .af_sel(af_sel), .irq(irq)
  );

  // monitor: read data is due the cycle after the strobe
  always @(posedge clk) rd_q <= bus_rd;
  always @(negedge clk) begin
    if (rd_q) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (bus_rdata !== e) begin
        n_bad++;
        $display("FAIL %s read actual=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic bus_write(input int a, input logic [31:0] d);
    bus_addr  = AW'(a);
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input int a, input logic [31:0] e, input string t);
    bus_addr = AW'(a);
    bus_rd   = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_rd   = 1'b0;
  endtask

  task automatic chk(input string t, input logic [2*NP-1:0] act, input logic [2*NP-1:0] e);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", t, act, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(5);

    // R12 reset state
    chk("R12 pin_oe", {96'h0, pin_oe}, '0);
    chk("R12 pin_out", {96'h0, pin_out}, '0);
    chk("R12 af_sel", af_sel, '0);
    chk("R12 irq", {191'h0, irq}, '0);
    bus_read(4, 32'h0, "R12 dir word1");
    bus_read(12, 32'h0, "R12 rise word0");

    // R1 R3 direction in bank 1 (word 1*3+1)
    bus_write(4, 32'h0000_FF00);
    chk("R3 pin_oe", {96'h0, pin_oe}, {96'h0, 96'h00000000_0000FF00_00000000});
    bus_read(4, 32'h0000_FF00, "R3 dir readback");

    // R4 R5 set/clear ports, bank 1
    bus_write(7, 32'h0000_0F00);
    chk("R4 set", {96'h0, pin_out}, {96'h0, 96'h00000000_00000F00_00000000});
    bus_write(10, 32'h0000_0300);
    chk("R5 clear", {96'h0, pin_out}, {96'h0, 96'h00000000_00000C00_00000000});
    bus_read(7, 32'h0, "R4 set reads 0");
    bus_read(10, 32'h0, "R5 clear reads 0");

    // R1 R2 level readback
    pin_in = 96'hA5A50000_12345678_000000C3;
    idle(3);
    bus_read(0, 32'h0000_00C3, "R2 level w0");
    bus_read(1, 32'h1234_5678, "R1 level w1");
    bus_read(2, 32'hA5A5_0000, "R1 level w2");
    bus_write(0, 32'hFFFF_FFFF);
    bus_read(0, 32'h0000_00C3, "R2 level write ignored");

    pin_in = '0;
    idle(4);

    // R6 rising edge on pin 5
    bus_write(12, 32'h0000_0020);
    pin_in[5] = 1'b1;
    idle(4);
    chk("R6 irq after rise", {191'h0, irq}, 192'h1);
    bus_read(18, 32'h0000_0020, "R6 status");
    pin_in[5] = 1'b0;
    idle(4);
    bus_read(18, 32'h0000_0020, "R8 fall not enabled");
    bus_write(18, 32'h0000_0020);
    chk("R10 irq after clear", {191'h0, irq}, '0);
    bus_read(18, 32'h0, "R9 cleared");

    // R7 falling edge on pin 70 (bank 2 bit 6)
    bus_write(17, 32'h0000_0040);
    pin_in[70] = 1'b1;
    idle(4);
    chk("R8 rise not enabled irq", {191'h0, irq}, '0);
    pin_in[70] = 1'b0;
    idle(4);
    chk("R7 irq after fall", {191'h0, irq}, 192'h1);
    bus_read(20, 32'h0000_0040, "R7 status");
    bus_write(20, 32'h0000_0040);
    chk("R10 irq low", {191'h0, irq}, '0);

    // R9 edge coinciding with clearing write, pin 9
    bus_write(12, 32'h0000_0220);
    pin_in[9] = 1'b1;
    idle(4);
    bus_read(18, 32'h0000_0200, "R6 pin9 status");
    pin_in[9] = 1'b0;
    idle(4);
    pin_in[9] = 1'b1;
    idle(2);
    bus_write(18, 32'h0000_0200);
    chk("R9 coincident edge kept irq", {191'h0, irq}, 192'h1);
    bus_read(18, 32'h0000_0200, "R9 coincident edge kept");
    bus_write(18, 32'h0000_0200);
    bus_read(18, 32'h0, "R9 second clear");
    chk("R10 irq idle", {191'h0, irq}, '0);

    // R11 function code for pin 17: word 22, bits 3:2
    bus_write(22, 32'h0000_000C);
    chk("R11 af_sel", af_sel, 192'd3 << 34);
    bus_read(22, 32'h0000_000C, "R11 func readback");

    // R13 out of range
    bus_write(40, 32'hFFFF_FFFF);
    bus_write(27, 32'hFFFF_FFFF);
    bus_read(40, 32'h0, "R13 read 40");
    bus_read(27, 32'h0, "R13 read 27");
    chk("R13 pin_oe unchanged", {96'h0, pin_oe}, {96'h0, 96'h00000000_0000FF00_00000000});
    chk("R13 af_sel unchanged", af_sel, 192'd3 << 34);
    bus_read(4, 32'h0000_FF00, "R13 dir unchanged");

    idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule